// File: doc/BRIEF.md
# SDRAM Command Legality and Bank Tracker

This block watches the command and address bus of a four-bank SDRAM and does not drive it. On every rising clock edge it decodes the chip select, row strobe, column strobe, write enable and clock-enable pins into a command. It keeps a small state machine and a cycle-age counter for each bank. Each command is checked against the state of the bank it targets and against the spacing timers. A command that breaks a rule is reported through a one-cycle violation strobe and a code, and it is then dropped, so the tracked state always describes what a compliant device would hold.

Auto-precharge is modelled as a hidden precharge. After a read or write with A10 high, the bank stays in a locked state for a burst length of cycles, then precharges for tRP cycles, then returns to idle. Refresh, mode-register load, self-refresh entry and power-down entry are checked against all banks at once. Timing limits and the burst length are parameters given in clock cycles.

Top module: `sdram_cmd_guard`

## Requirements
- R1: A command is decoded only when CKE was high at the previous edge. Deselect (cs_n high), the no-operation encoding (ras_n,cas_n,we_n = 1,1,1) and the burst-stop encoding (1,1,0) leave every bank unchanged and raise no violation. The exception is a CKE fall from high to low with no other command, which is a power-down entry.
- R2: After reset, every bank reads idle (state code 00), viol is low and viol_code is zero.
- R3: ACT (0,1,1) on an idle bank makes that bank active (01). ACT on a bank that is active (01) or locked by auto-precharge (10) is an illegal-state violation.
- R4: READ (1,0,1) or WRITE (1,0,0) on a bank that is not active is an illegal-state violation. On an active bank it is a timing violation when it comes fewer than tRCD cycles after that bank's ACT.
- R5: An ACT fewer than tRRD cycles after the previous accepted ACT to any bank is a timing violation.
- R6: PRE (0,1,0) on an active bank moves it to precharging (11) for tRP cycles, after which it is idle. PRE fewer than tRAS cycles after ACT is a timing violation. ACT on a precharging bank is a timing violation. PRE on an idle bank is accepted and has no effect.
- R7: PRE with A10 high applies to every bank, whatever BA says.
- R8: READ or WRITE with A10 high puts the bank in the locked state (10) for BL cycles, then in precharging (11) for tRP cycles. ACT becomes legal BL+tRP cycles after the command. ACT, READ, WRITE and PRE to a locked bank are illegal-state violations.
- R9: Auto-refresh (0,0,1 with CKE high), self-refresh entry (0,0,1 with CKE falling), mode-register load (0,0,0) and power-down entry are illegal-state violations unless every bank is idle. The offending bank is reported.
- R10: viol rises in the cycle after the offending command's edge. viol_code is {kind, bank}, where kind is 01 for illegal state and 10 for timing, and it is zero whenever viol is low. When several banks fail, the lowest-numbered one is reported. Within a bank, an illegal-state error outranks a timing error.
- R11: A command that raises a violation changes no bank state and does not restart the ACT spacing timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge samples the command |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank address |
| a10 | input | 1 | All-bank / auto-precharge qualifier |
| bank_state | output | 8 | Two bits per bank, bank i at [2i+1:2i]: 00 idle, 01 active, 10 auto-precharge locked, 11 precharging |
| viol | output | 1 | Violation strobe, one cycle |
| viol_code | output | 4 | {kind[1:0], bank[1:0]} of the reported violation |

## Verification
Every result of this block is due in the cycle after the edge that samples the command. That covers the new bank state, the strobe and the code. Automatic transitions land on fixed edges counted from the command: the lock ends BL edges after READA or WRITEA, and the precharge ends tRP edges after it starts. The bench drives each command on a falling edge and reads the outputs at the next falling edge, once the single register stage has updated. Timer scenarios pad the gap with a counted number of idle cycles, so each check falls on a known cycle: either one short of a limit or exactly on it.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [3:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE,
    CMD_REF, CMD_SREF, CMD_MRS, CMD_PDN
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'b00,
    BK_ACTIVE = 2'b01,
    BK_LOCKED = 2'b10,
    BK_PRECH  = 2'b11
  } bank_st_e;

  localparam logic [1:0] VK_NONE  = 2'b00;
  localparam logic [1:0] VK_STATE = 2'b01;
  localparam logic [1:0] VK_TIME  = 2'b10;

  // Pin decode; a cycle whose previous CKE was low is suspended.
  function automatic cmd_e decode_cmd(input logic cke_prev, input logic cke,
                                      input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    c = CMD_NOP;
    if (cke_prev) begin
      if (cs_n) c = cke ? CMD_NOP : CMD_PDN;
      else begin
        case ({ras_n, cas_n, we_n})
          3'b111:  c = cke ? CMD_NOP : CMD_PDN;
          3'b011:  c = CMD_ACT;
          3'b101:  c = CMD_RD;
          3'b100:  c = CMD_WR;
          3'b010:  c = CMD_PRE;
          3'b001:  c = cke ? CMD_REF : CMD_SREF;
          3'b000:  c = CMD_MRS;
          default: c = CMD_NOP;
        endcase
      end
    end
    return c;
  endfunction

  function automatic logic needs_all_idle(input cmd_e c);
    return (c == CMD_REF) || (c == CMD_SREF) || (c == CMD_MRS) || (c == CMD_PDN);
  endfunction

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdg_decode.sv
module sdg_decode
  import sdram_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  output cmd_e cmd
);
  logic cke_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_prev <= 1'b1;
    else        cke_prev <= cke;
  end

  assign cmd = decode_cmd(cke_prev, cke, cs_n, ras_n, cas_n, we_n);
endmodule

// File: rtl/sdg_bank.sv
module sdg_bank
  import sdram_guard_pkg::*;
#(
  parameter int TRCD = 3,
  parameter int TRAS = 6,
  parameter int TRP  = 3,
  parameter int BL   = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cmd_e     cmd,
  input  logic     hit,
  input  logic     auto_pre,
  input  logic     commit,
  output bank_st_e st,
  output logic     err_state,
  output logic     err_time
);
  localparam int CAPV = max_of4(TRCD, TRAS, TRP, BL);
  localparam int AW   = $clog2(CAPV + 1);
  localparam logic [AW-1:0] AGE_CAP  = AW'(CAPV);
  localparam logic [AW-1:0] RCD_L    = AW'(TRCD);
  localparam logic [AW-1:0] RAS_L    = AW'(TRAS);
  localparam logic [AW-1:0] BL_L     = AW'(BL);
  localparam logic [AW-1:0] PRE_LAST = AW'(TRP > 1 ? TRP - 1 : 1);
  localparam bank_st_e AFTER_PRE     = (TRP > 1) ? BK_PRECH : BK_IDLE;

  logic [AW-1:0] age, nage;
  bank_st_e      nst;

  always_comb begin
    err_state = 1'b0;
    err_time  = 1'b0;
    if (hit) begin
      case (cmd)
        CMD_ACT: begin
          if (st == BK_PRECH)     err_time  = 1'b1;
          else if (st != BK_IDLE) err_state = 1'b1;
        end
        CMD_RD, CMD_WR: begin
          if (st != BK_ACTIVE)    err_state = 1'b1;
          else if (age < RCD_L)   err_time  = 1'b1;
        end
        CMD_PRE: begin
          if (st == BK_LOCKED)    err_state = 1'b1;
          else if (st == BK_ACTIVE && age < RAS_L) err_time = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    nst  = st;
    nage = (age == AGE_CAP) ? age : age + 1'b1;
    case (st)
      BK_LOCKED: if (age == BL_L) begin
        nst  = AFTER_PRE;
        nage = AW'(1);
      end
      BK_PRECH: if (age >= PRE_LAST) nst = BK_IDLE;
      default: ;
    endcase
    if (commit && hit) begin
      case (cmd)
        CMD_ACT: begin
          nst  = BK_ACTIVE;
          nage = AW'(1);
        end
        CMD_RD, CMD_WR: if (auto_pre) begin
          nst  = BK_LOCKED;
          nage = AW'(1);
        end
        CMD_PRE: if (st == BK_ACTIVE) begin
          nst  = AFTER_PRE;
          nage = AW'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= BK_IDLE;
      age <= AGE_CAP;
    end else begin
      st  <= nst;
      age <= nage;
    end
  end
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdram_guard_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int TRRD  = 2,
  parameter int TRCD  = 3,
  parameter int TRP   = 3,
  parameter int TRAS  = 6,
  parameter int BL    = 4,
  localparam int BAW  = $clog2(NBANK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 cke,
  input  logic [BAW-1:0]       ba,
  input  logic                 a10,
  output logic [2*NBANK-1:0]   bank_state,
  output logic                 viol,
  output logic [BAW+1:0]       viol_code
);
  localparam int RW = $clog2(TRRD + 1);
  localparam logic [RW-1:0] RRD_L = RW'(TRRD);

  cmd_e           cmd;
  bank_st_e       st      [NBANK];
  logic [NBANK-1:0] hit, e_state, e_time, nonidle;
  logic [RW-1:0]  rrd_cnt;
  logic           rrd_err, idle_err, any_err, commit;
  logic [1:0]     rep_kind;
  logic [BAW-1:0] rep_bank;

  sdg_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke(cke), .cmd(cmd)
  );

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    assign hit[i] = ((cmd == CMD_PRE) && a10) || (ba == BAW'(i));
    assign nonidle[i] = (st[i] != BK_IDLE);
    assign bank_state[2*i +: 2] = st[i];
    sdg_bank #(.TRCD(TRCD), .TRAS(TRAS), .TRP(TRP), .BL(BL)) u_bank (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .hit(hit[i]), .auto_pre(a10),
      .commit(commit), .st(st[i]), .err_state(e_state[i]), .err_time(e_time[i])
    );
  end

  assign rrd_err  = (cmd == CMD_ACT) && (rrd_cnt < RRD_L);
  assign idle_err = needs_all_idle(cmd) && (|nonidle);

  // Lowest failing bank wins; state errors outrank timing errors.
  always_comb begin
    any_err  = 1'b0;
    rep_kind = VK_NONE;
    rep_bank = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (e_state[i] || (idle_err && nonidle[i])) begin
        any_err  = 1'b1;
        rep_kind = VK_STATE;
        rep_bank = BAW'(i);
      end else if (e_time[i] || (rrd_err && ba == BAW'(i))) begin
        any_err  = 1'b1;
        rep_kind = VK_TIME;
        rep_bank = BAW'(i);
      end
    end
  end

  assign commit = !any_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_cnt   <= RRD_L;
      viol      <= 1'b0;
      viol_code <= '0;
    end else begin
      if (commit && cmd == CMD_ACT)  rrd_cnt <= RW'(1);
      else if (rrd_cnt < RRD_L)      rrd_cnt <= rrd_cnt + 1'b1;
      viol      <= any_err;
      viol_code <= any_err ? {rep_kind, rep_bank} : '0;
    end
  end
endmodule

// File: rtl/sdram_cmd_guard_chk.sv
module sdram_cmd_guard_chk #(
  parameter int NBANK = 4,
  parameter int TRP   = 3,
  localparam int BAW  = $clog2(NBANK)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_n,
  input logic               cke,
  input logic [2*NBANK-1:0] bank_state,
  input logic               viol,
  input logic [BAW+1:0]     viol_code
);
  logic [2*NBANK-1:0] prev_state;
  logic [NBANK-1:0]   opened;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_state <= '0;
    else        prev_state <= bank_state;
  end

  for (genvar i = 0; i < NBANK; i++) begin : g_open
    assign opened[i] = (prev_state[2*i +: 2] == 2'b00) && (bank_state[2*i +: 2] == 2'b01);
  end

  // R10
  code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |-> viol_code == '0);

  // R10
  code_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (viol_code[BAW+1:BAW] == 2'b01 || viol_code[BAW+1:BAW] == 2'b10));

  // R1
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cke) |=> !viol);

  // R5
  single_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(opened) <= 1);

  for (genvar i = 0; i < NBANK; i++) begin : g_bank_chk
    // R3
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_state[2*i +: 2] == 2'b00 |=> bank_state[2*i +: 2] inside {2'b00, 2'b01});
    // R6
    prech_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_state[2*i +: 2] == 2'b11 |=> bank_state[2*i +: 2] inside {2'b11, 2'b00});
    // R8
    locked_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_state[2*i +: 2] == 2'b10 |=>
        (bank_state[2*i +: 2] inside {2'b10, 2'b11} ||
         (TRP <= 1 && bank_state[2*i +: 2] == 2'b00)));
  end
endmodule

bind sdram_cmd_guard sdram_cmd_guard_chk #(.NBANK(NBANK), .TRP(TRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cke(cke),
  .bank_state(bank_state), .viol(viol), .viol_code(viol_code)
);

// File: tb/sdram_cmd_guard_test.sv
`timescale 1ns/1ps
module sdram_cmd_guard_test;
  localparam logic [2:0] E_NOP  = 3'b111;
  localparam logic [2:0] E_STOP = 3'b110;
  localparam logic [2:0] E_ACT  = 3'b011;
  localparam logic [2:0] E_RD   = 3'b101;
  localparam logic [2:0] E_WR   = 3'b100;
  localparam logic [2:0] E_PRE  = 3'b010;
  localparam logic [2:0] E_REF  = 3'b001;
  localparam logic [2:0] E_MRS  = 3'b000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic [7:0] bank_state;
  logic       viol;
  logic [3:0] viol_code;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_cmd_guard uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .a10(a10),
    .bank_state(bank_state), .viol(viol), .viol_code(viol_code)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int bst(input int b);
    return int'(bank_state[2*b +: 2]);
  endfunction

  task automatic send(input logic [2:0] e, input int b, input logic ap,
                      input logic k, input logic sel_off = 1'b0);
    cs_n = sel_off;
    {ras_n, cas_n, we_n} = e;
    ba = b[1:0];
    a10 = ap;
    cke = k;
    @(negedge clk);
    cs_n = 1'b0;
    {ras_n, cas_n, we_n} = E_NOP;
    a10 = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    cs_n = 1'b1;
    cke = 1'b1;
    {ras_n, cas_n, we_n} = E_NOP;
    idle(2);
    rst_n = 1'b1;
    cs_n = 1'b0;
  endtask

  task automatic t_reset;
    do_reset;
    chk("R2", "bank_state", bank_state, 0);
    chk("R2", "viol", viol, 0);
    chk("R2", "viol_code", viol_code, 0);
  endtask

  task automatic t_decode;
    do_reset;
    send(E_ACT, 0, 1'b0, 1'b1, 1'b1);
    chk("R1", "deselected ACT state", bank_state, 0);
    chk("R1", "deselected ACT viol", viol, 0);
    send(E_STOP, 0, 1'b0, 1'b1);
    chk("R1", "burst stop viol", viol, 0);
    send(E_NOP, 0, 1'b0, 1'b0);
    chk("R1", "power-down entry all idle", viol, 0);
    send(E_ACT, 0, 1'b0, 1'b0);
    chk("R1", "suspended ACT", bst(0), 0);
    send(E_NOP, 0, 1'b0, 1'b1);
    send(E_ACT, 0, 1'b0, 1'b1);
    chk("R1", "ACT after wake", bst(0), 1);
    chk("R1", "ACT after wake viol", viol, 0);
  endtask

  task automatic t_act_rd;
    do_reset;
    send(E_ACT, 0, 1'b0, 1'b1);
    chk("R3", "ACT idle bank", bst(0), 1);
    send(E_RD, 0, 1'b0, 1'b1);
    chk("R4", "READ before tRCD", viol_code, 4'b1000);
    idle(1);
    send(E_RD, 0, 1'b0, 1'b1);
    chk("R4", "READ at tRCD", viol, 0);
    send(E_WR, 3, 1'b0, 1'b1);
    chk("R4", "WRITE idle bank", viol_code, 4'b0111);
    send(E_ACT, 0, 1'b0, 1'b1);
    chk("R3", "ACT active bank", viol_code, 4'b0100);
  endtask

  task automatic t_rrd;
    do_reset;
    send(E_ACT, 1, 1'b0, 1'b1);
    send(E_ACT, 2, 1'b0, 1'b1);
    chk("R5", "ACT under tRRD", viol_code, 4'b1010);
    chk("R11", "rejected ACT state", bst(2), 0);
    send(E_ACT, 2, 1'b0, 1'b1);
    chk("R5", "ACT at tRRD", viol, 0);
    chk("R5", "two banks open", bank_state, 8'h14);
  endtask

  task automatic t_pre;
    do_reset;
    send(E_ACT, 2, 1'b0, 1'b1);
    send(E_PRE, 2, 1'b0, 1'b1);
    chk("R6", "PRE under tRAS", viol_code, 4'b1010);
    chk("R11", "rejected PRE state", bst(2), 1);
    idle(4);
    send(E_PRE, 2, 1'b0, 1'b1);
    chk("R6", "PRE at tRAS viol", viol, 0);
    chk("R6", "precharging", bst(2), 3);
    send(E_ACT, 2, 1'b0, 1'b1);
    chk("R6", "ACT during tRP", viol_code, 4'b1010);
    idle(1);
    chk("R6", "idle after tRP", bst(2), 0);
    send(E_ACT, 2, 1'b0, 1'b1);
    chk("R6", "ACT after tRP", bst(2), 1);
    send(E_PRE, 1, 1'b0, 1'b1);
    chk("R6", "PRE idle bank viol", viol, 0);
    chk("R6", "PRE idle bank state", bst(1), 0);
  endtask

  task automatic t_prea;
    do_reset;
    send(E_ACT, 0, 1'b0, 1'b1);
    idle(1);
    send(E_ACT, 3, 1'b0, 1'b1);
    send(E_PRE, 1, 1'b1, 1'b1);
    chk("R7", "early all-bank PRE code", viol_code, 4'b1000);
    chk("R11", "early all-bank PRE state", bank_state, 8'h41);
    idle(4);
    send(E_PRE, 1, 1'b1, 1'b1);
    chk("R7", "all-bank PRE viol", viol, 0);
    chk("R7", "all-bank PRE state", bank_state, 8'hC3);
  endtask

  task automatic t_autopre;
    do_reset;
    send(E_ACT, 1, 1'b0, 1'b1);
    idle(2);
    send(E_RD, 1, 1'b1, 1'b1);
    chk("R8", "READA locks", bst(1), 2);
    send(E_PRE, 1, 1'b0, 1'b1);
    chk("R8", "PRE to locked", viol_code, 4'b0101);
    send(E_RD, 1, 1'b0, 1'b1);
    chk("R8", "READ to locked", viol_code, 4'b0101);
    idle(1);
    chk("R8", "still locked", bst(1), 2);
    idle(1);
    chk("R8", "hidden precharge", bst(1), 3);
    send(E_ACT, 1, 1'b0, 1'b1);
    chk("R8", "ACT before BL+tRP", viol_code, 4'b1001);
    idle(1);
    send(E_ACT, 1, 1'b0, 1'b1);
    chk("R8", "ACT at BL+tRP", viol, 0);
    chk("R8", "reopened", bst(1), 1);
    do_reset;
    send(E_ACT, 0, 1'b0, 1'b1);
    idle(2);
    send(E_WR, 0, 1'b1, 1'b1);
    chk("R8", "WRITEA locks", bst(0), 2);
  endtask

  task automatic t_idle_only;
    do_reset;
    send(E_REF, 0, 1'b0, 1'b1);
    chk("R9", "REFA all idle", viol, 0);
    send(E_MRS, 0, 1'b0, 1'b1);
    chk("R9", "MRS all idle", viol, 0);
    send(E_ACT, 2, 1'b0, 1'b1);
    send(E_REF, 0, 1'b0, 1'b1);
    chk("R9", "REFA bank open", viol_code, 4'b0110);
    send(E_MRS, 0, 1'b0, 1'b1);
    chk("R9", "MRS bank open", viol_code, 4'b0110);
    send(E_REF, 0, 1'b0, 1'b0);
    chk("R9", "self-refresh entry bank open", viol_code, 4'b0110);
    send(E_NOP, 0, 1'b0, 1'b1);
    chk("R1", "suspended cycle", viol, 0);
    send(E_NOP, 0, 1'b0, 1'b0);
    chk("R9", "power-down entry bank open", viol_code, 4'b0110);
    send(E_NOP, 0, 1'b0, 1'b1);
  endtask

  task automatic t_lowest;
    do_reset;
    send(E_ACT, 1, 1'b0, 1'b1);
    idle(1);
    send(E_ACT, 3, 1'b0, 1'b1);
    send(E_REF, 0, 1'b0, 1'b1);
    chk("R10", "lowest bank reported", viol_code, 4'b0101);
    chk("R10", "strobe", viol, 1);
    send(E_NOP, 0, 1'b0, 1'b1);
    chk("R10", "strobe clears", viol, 0);
    chk("R10", "code clears", viol_code, 0);
  endtask

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_decode;
    t_act_rd;
    t_rrd;
    t_pre;
    t_prea;
    t_autopre;
    t_idle_only;
    t_lowest;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule